// File: doc/BRIEF.md
# Receive Slot Ring with Run-Time Depth

This block keeps the bookkeeping for a receive queue built from a pool of eight message slots. Slots 0 and 1 always receive. Slots 2 to 7 are programmable, and each can be set to transmit or receive. The queue starts at slot 0 and runs over consecutive receive slots. It stops just before the lowest-numbered programmable slot that is set to transmit. The block holds only slot indices, occupancy flags and status. Message payloads are stored elsewhere.

A frame filter pulses `accept_i` for each message it accepts. The block answers with the slot the message lands in (`wr_slot_o`) and marks that slot full. The host reads the oldest message at `rd_ptr_o`. It then clears that slot's flag through `clr_done_i`, and the read pointer moves to the next slot. The block also reports when the queue is empty, gives a reception code and a selectable early-warning watermark, and keeps a sticky overflow flag.

Top module: `rxq_ring`

## Requirements
- R1: The active depth is 2 plus k, where k is the index of the lowest set bit of `prog_tx_i`. Bit k of `prog_tx_i` set means programmable slot k (pool slot 2+k) transmits. With no bit set the depth is 8. Examples: bit 3 lowest gives 5, bit 0 gives 2, none gives 8.
- R2: An accepted message is stored in slot `wr_slot_o`, and `full_o[wr_slot_o]` is set one cycle later. `full_o` bit s is pool slot s. `wr_slot_o` then advances by one, and from depth-1 it wraps to 0.
- R3: An accept that arrives while all depth slots are full is dropped, even if a clear comes in the same cycle. `full_o` does not change, and `ovf_o` rises one cycle later. `ovf_o` stays high until a cycle with `ovf_clr_i` high and no new drop.
- R4: When `clr_done_i` has a 1 at the bit of the slot named by `rd_ptr_o`, and that slot is full, its flag clears one cycle later. `rd_ptr_o` then advances by one, and from depth-1 it wraps to 0.
- R5: A 1 in `clr_done_i` at any bit other than the one at `rd_ptr_o` is ignored, and `full_o` does not change.
- R6: `empty_o` is high exactly when the full flag of the slot at `rd_ptr_o` is clear.
- R7: `int_code_o` is 5'b10000 for the single cycle after each stored accept. Otherwise it is 5'b00000, and a dropped accept gives no code.
- R8: `wm_irq_o` is high when free slots (depth minus stored messages) equal 1 with `wm_sel_i`=0, or equal 4 with `wm_sel_i`=1.
- R9: A change of `prog_tx_i` takes effect only on a cycle where the queue is empty and no accept arrives. When that changes the depth, both pointers return to slot 0.
- R10: Synchronous reset clears every full flag and the overflow flag, sets both pointers to 0 and the code to 0, and loads the depth from `prog_tx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept_i | input | 1 | One accepted message to store |
| prog_tx_i | input | 6 | Transmit setting per programmable slot |
| clr_done_i | input | 8 | Host releases a slot after reading it |
| wm_sel_i | input | 1 | Watermark level: 0 one free, 1 four free |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| wr_slot_o | output | 4 | Slot that the next accepted message fills |
| rd_ptr_o | output | 4 | Slot holding the oldest unread message |
| full_o | output | 8 | Occupancy flag per pool slot |
| empty_o | output | 1 | No unread message |
| int_code_o | output | 5 | Reception code |
| wm_irq_o | output | 1 | Early-warning watermark |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The block stores the effect of each accept or clear in registers at the clock edge where the input is seen. So `full_o`, both pointers, `ovf_o` and `int_code_o` are due one cycle after that stimulus. `empty_o` and `wm_irq_o` are decoded from that stored state in the same cycle, and `wm_irq_o` also follows `wm_sel_i` without delay. The bench applies each stimulus between edges, waits one rising edge, and then samples all outputs a short time after the edge. The depth reload is a one-cycle delay of its own: an idle empty cycle is spent before the new depth is tested.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int FIXED_SLOTS = 2;
    localparam int PROG_SLOTS  = 6;
    localparam int CODE_W      = 5;

    localparam logic [CODE_W-1:0] CODE_RING_RX = 5'b10000;
    localparam logic [CODE_W-1:0] CODE_NONE    = 5'b00000;

    localparam int FREE_NEAR = 1;
    localparam int FREE_FAR  = 4;

    typedef enum logic {
        WM_ONE_FREE  = 1'b0,
        WM_FOUR_FREE = 1'b1
    } wm_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
        logic reload;
    } ring_op_t;

    function automatic int ring_next(int p, int depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rxq_depth_sel.sv
module rxq_depth_sel #(
    parameter int FIXED = 2,
    parameter int PROG  = 6,
    parameter int CW    = 4
) (
    input  logic [PROG-1:0] tx_cfg,
    output logic [CW-1:0]   depth
);
    always_comb begin
        depth = CW'(FIXED + PROG);
        for (int k = PROG - 1; k >= 0; k--) begin
            if (tx_cfg[k]) depth = CW'(FIXED + k);
        end
    end
endmodule

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
    parameter int IW = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          home,
    input  logic [CW-1:0] depth,
    output logic [IW-1:0] ptr
);
    import rxq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || home) ptr <= '0;
        else if (adv)    ptr <= IW'(ring_next(int'(ptr), int'(depth)));
    end
endmodule

// File: rtl/rxq_occ.sv
module rxq_occ #(
    parameter int SLOTS = 8,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IW-1:0]    set_idx,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    output logic [SLOTS-1:0] full
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                full[g] <= 1'b0;
            else if (set_en && set_idx == IW'(g))
                full[g] <= 1'b1;
            else if (clr_en && clr_idx == IW'(g))
                full[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int FIXED = rxq_pkg::FIXED_SLOTS,
    parameter int PROG  = rxq_pkg::PROG_SLOTS,
    parameter int IW    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept_i,
    input  logic [PROG-1:0]      prog_tx_i,
    input  logic [FIXED+PROG-1:0] clr_done_i,
    input  logic                 wm_sel_i,
    input  logic                 ovf_clr_i,
    output logic [IW-1:0]        wr_slot_o,
    output logic [IW-1:0]        rd_ptr_o,
    output logic [FIXED+PROG-1:0] full_o,
    output logic                 empty_o,
    output logic [4:0]           int_code_o,
    output logic                 wm_irq_o,
    output logic                 ovf_o
);
    import rxq_pkg::*;

    localparam int SLOTS = FIXED + PROG;
    localparam int CW    = $clog2(SLOTS + 1);

    logic [CW-1:0]    cfg_depth;
    logic [CW-1:0]    depth_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    free_slots;
    logic [SLOTS-1:0] rd_sel;
    logic             home;
    ring_op_t         op;

    rxq_depth_sel #(.FIXED(FIXED), .PROG(PROG), .CW(CW)) u_depth (
        .tx_cfg (prog_tx_i),
        .depth  (cfg_depth)
    );

    always_comb begin
        for (int s = 0; s < SLOTS; s++) rd_sel[s] = (rd_ptr_o == IW'(s));
    end

    always_comb begin
        op.push   = accept_i && (cnt_q != depth_q);
        op.drop   = accept_i && (cnt_q == depth_q);
        op.pop    = |(clr_done_i & full_o & rd_sel);
        op.reload = (cnt_q == '0) && !accept_i;
    end

    assign home = op.reload && (cfg_depth != depth_q);

    rxq_ptr #(.IW(IW), .CW(CW)) u_wr (
        .clk (clk), .rst (rst), .adv (op.push), .home (home),
        .depth (depth_q), .ptr (wr_slot_o)
    );

    rxq_ptr #(.IW(IW), .CW(CW)) u_rd (
        .clk (clk), .rst (rst), .adv (op.pop), .home (home),
        .depth (depth_q), .ptr (rd_ptr_o)
    );

    rxq_occ #(.SLOTS(SLOTS), .IW(IW)) u_occ (
        .clk (clk), .rst (rst),
        .set_en (op.push), .set_idx (wr_slot_o),
        .clr_en (op.pop),  .clr_idx (rd_ptr_o),
        .full (full_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q    <= cfg_depth;
            cnt_q      <= '0;
            ovf_o      <= 1'b0;
            int_code_o <= CODE_NONE;
        end else begin
            if (op.reload) depth_q <= cfg_depth;
            case ({op.push, op.pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (op.drop)        ovf_o <= 1'b1;
            else if (ovf_clr_i) ovf_o <= 1'b0;
            int_code_o <= op.push ? CODE_RING_RX : CODE_NONE;
        end
    end

    assign free_slots = depth_q - cnt_q;
    assign empty_o    = ~|(full_o & rd_sel);

    always_comb begin
        if (wm_mode_e'(wm_sel_i) == WM_FOUR_FREE)
            wm_irq_o = (free_slots == CW'(FREE_FAR));
        else
            wm_irq_o = (free_slots == CW'(FREE_NEAR));
    end
endmodule

// File: rtl/rxq_ring_chk.sv
module rxq_ring_chk #(
    parameter int SLOTS = 8,
    parameter int IW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             accept_i,
    input logic [SLOTS-1:0] clr_done_i,
    input logic             ovf_clr_i,
    input logic [IW-1:0]    rd_ptr_o,
    input logic [SLOTS-1:0] full_o,
    input logic             empty_o,
    input logic [4:0]       int_code_o,
    input logic             ovf_o
);
    logic [SLOTS-1:0] rd_bits;
    logic             rd_hit;

    assign rd_bits = (clr_done_i & full_o) >> rd_ptr_o;
    assign rd_hit  = rd_bits[0];

    p_rd_advance_r4: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> rd_ptr_o != $past(rd_ptr_o));

    p_clr_other_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (!accept_i && !rd_hit) |=> full_o == $past(full_o));

    p_empty_flags_r6: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> full_o == '0);

    p_ovf_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(accept_i));

    p_int_value_r7: assert property (@(posedge clk) disable iff (rst)
        int_code_o == 5'b10000 || int_code_o == 5'b00000);

    p_int_cause_r7: assert property (@(posedge clk) disable iff (rst)
        int_code_o == 5'b10000 |-> $past(accept_i));
endmodule

bind rxq_ring rxq_ring_chk #(.SLOTS(FIXED + PROG), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept_i),
    .clr_done_i (clr_done_i),
    .ovf_clr_i  (ovf_clr_i),
    .rd_ptr_o   (rd_ptr_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .int_code_o (int_code_o),
    .ovf_o      (ovf_o)
);

// File: tb/sim_rxq_ring.sv
module sim_rxq_ring;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       accept_i = 1'b0;
    logic [5:0] prog_tx_i = 6'b0;
    logic [7:0] clr_done_i = 8'h00;
    logic       wm_sel_i = 1'b0;
    logic       ovf_clr_i = 1'b0;
    logic [3:0] wr_slot_o, rd_ptr_o;
    logic [7:0] full_o;
    logic       empty_o, wm_irq_o, ovf_o;
    logic [4:0] int_code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rxq_ring u0 (
        .clk (clk), .rst (rst), .accept_i (accept_i), .prog_tx_i (prog_tx_i),
        .clr_done_i (clr_done_i), .wm_sel_i (wm_sel_i), .ovf_clr_i (ovf_clr_i),
        .wr_slot_o (wr_slot_o), .rd_ptr_o (rd_ptr_o), .full_o (full_o),
        .empty_o (empty_o), .int_code_o (int_code_o), .wm_irq_o (wm_irq_o),
        .ovf_o (ovf_o)
    );

    typedef struct packed {
        logic       acc;
        logic [7:0] clr;
        logic       wm;
        logic [3:0] wr;
        logic [3:0] rd;
        logic [7:0] full;
        logic       empty;
        logic [4:0] code;
        logic       wmirq;
        logic       ovf;
    } vec_t;

    // depth 8; each row: stimulus, then state one edge later
    localparam vec_t VECS [9] = '{
        '{1'b1, 8'h00, 1'b0, 4'd1, 4'd0, 8'h01, 1'b0, 5'h10, 1'b0, 1'b0},
        '{1'b1, 8'h00, 1'b0, 4'd2, 4'd0, 8'h03, 1'b0, 5'h10, 1'b0, 1'b0},
        '{1'b0, 8'h02, 1'b0, 4'd2, 4'd0, 8'h03, 1'b0, 5'h00, 1'b0, 1'b0},
        '{1'b0, 8'h01, 1'b0, 4'd2, 4'd1, 8'h02, 1'b0, 5'h00, 1'b0, 1'b0},
        '{1'b1, 8'h02, 1'b0, 4'd3, 4'd2, 8'h04, 1'b0, 5'h10, 1'b0, 1'b0},
        '{1'b1, 8'h00, 1'b1, 4'd4, 4'd2, 8'h0C, 1'b0, 5'h10, 1'b0, 1'b0},
        '{1'b1, 8'h00, 1'b1, 4'd5, 4'd2, 8'h1C, 1'b0, 5'h10, 1'b0, 1'b0},
        '{1'b1, 8'h00, 1'b1, 4'd6, 4'd2, 8'h3C, 1'b0, 5'h10, 1'b1, 1'b0},
        '{1'b0, 8'h00, 1'b0, 4'd6, 4'd2, 8'h3C, 1'b0, 5'h00, 1'b0, 1'b0}
    };

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(logic acc, logic [7:0] clr, logic oc);
        accept_i   = acc;
        clr_done_i = clr;
        ovf_clr_i  = oc;
        @(posedge clk);
        #1;
        accept_i   = 1'b0;
        clr_done_i = 8'h00;
        ovf_clr_i  = 1'b0;
    endtask

    task automatic do_reset(logic [5:0] cfg);
        prog_tx_i = cfg;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(6'b000000);
        check("R10 wr", 8'(wr_slot_o), 8'd0);
        check("R10 rd", 8'(rd_ptr_o), 8'd0);
        check("R10 full", full_o, 8'h00);
        check("R6 empty after reset", 8'(empty_o), 8'd1);
        check("R10 code", 8'(int_code_o), 8'd0);
        check("R10 ovf", 8'(ovf_o), 8'd0);
        check("R8 wm idle", 8'(wm_irq_o), 8'd0);

        // table: R2 R4 R5 R6 R7 R8 at depth 8
        for (int i = 0; i < 9; i++) begin
            wm_sel_i = VECS[i].wm;
            step(VECS[i].acc, VECS[i].clr, 1'b0);
            check("R2 wr_slot", 8'(wr_slot_o), 8'(VECS[i].wr));
            check("R4 rd_ptr", 8'(rd_ptr_o), 8'(VECS[i].rd));
            check("R5 full", full_o, VECS[i].full);
            check("R6 empty", 8'(empty_o), 8'(VECS[i].empty));
            check("R7 code", 8'(int_code_o), 8'(VECS[i].code));
            check("R8 wm", 8'(wm_irq_o), 8'(VECS[i].wmirq));
            check("R3 ovf", 8'(ovf_o), 8'(VECS[i].ovf));
        end

        // R1: first transmit slot at bit 3 gives depth 5
        wm_sel_i = 1'b0;
        do_reset(6'b001000);
        for (int n = 0; n < 4; n++) step(1'b1, 8'h00, 1'b0);
        check("R8 one free at depth 5", 8'(wm_irq_o), 8'd1);
        step(1'b1, 8'h00, 1'b0);
        check("R1 depth5 full", full_o, 8'h1F);
        check("R2 wr wraps to 0", 8'(wr_slot_o), 8'd0);
        check("R1 no ovf at 5", 8'(ovf_o), 8'd0);
        check("R8 zero free", 8'(wm_irq_o), 8'd0);
        step(1'b1, 8'h00, 1'b0);
        check("R3 drop sets ovf", 8'(ovf_o), 8'd1);
        check("R3 drop keeps full", full_o, 8'h1F);
        check("R7 no code on drop", 8'(int_code_o), 8'd0);
        step(1'b0, 8'h00, 1'b0);
        check("R3 ovf held", 8'(ovf_o), 8'd1);
        step(1'b0, 8'h00, 1'b1);
        check("R3 ovf cleared", 8'(ovf_o), 8'd0);
        for (int s = 0; s < 4; s++) step(1'b0, 8'(1 << s), 1'b0);
        check("R4 rd at 4", 8'(rd_ptr_o), 8'd4);
        check("R6 not empty", 8'(empty_o), 8'd0);
        step(1'b0, 8'h10, 1'b0);
        check("R4 rd wraps to 0", 8'(rd_ptr_o), 8'd0);
        check("R6 empty after drain", 8'(empty_o), 8'd1);

        // R1: bit 0 transmit gives depth 2
        prog_tx_i = 6'b000001;
        step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        check("R1 depth2 full", full_o, 8'h03);
        check("R1 depth2 no ovf", 8'(ovf_o), 8'd0);
        step(1'b1, 8'h00, 1'b0);
        check("R1 depth2 third dropped", 8'(ovf_o), 8'd1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'h01, 1'b0);
        check("R4 rd after pop", 8'(rd_ptr_o), 8'd1);

        // R9: depth change held off while not empty
        prog_tx_i = 6'b000000;
        step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        check("R9 store at old depth", full_o, 8'h03);
        step(1'b1, 8'h00, 1'b0);
        check("R9 old depth still active", 8'(ovf_o), 8'd1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'h02, 1'b0);
        step(1'b0, 8'h01, 1'b0);
        check("R9 rd before reload", 8'(rd_ptr_o), 8'd1);
        step(1'b0, 8'h00, 1'b0);
        check("R9 rd homed", 8'(rd_ptr_o), 8'd0);
        check("R9 wr homed", 8'(wr_slot_o), 8'd0);
        for (int n = 0; n < 8; n++) step(1'b1, 8'h00, 1'b0);
        check("R1 depth8 full", full_o, 8'hFF);
        check("R1 depth8 no ovf", 8'(ovf_o), 8'd0);
        step(1'b1, 8'h00, 1'b0);
        check("R1 depth8 ninth dropped", 8'(ovf_o), 8'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule